// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block produces the control timing for a 320x240 RGB TFT panel from a single 50 MHz system clock. A divide-by-10 counter yields a one-cycle pixel enable at 5 MHz. Every other register in the block advances only on that enable, so the whole design stays in one clock domain and needs no derived clock.

A horizontal state machine moves each line through four phases: active, front porch, sync and back porch. A vertical sequencer counts lines and drives a vertical sync pulse at the start of each frame. The block outputs horizontal sync, vertical sync, a data-enable and the current column and row. Downstream pixel-fetch logic uses the column and row outputs as its read address.

The default line is 347 pixel periods, and a frame is 240 lines with no vertical blanking lines. That gives 832,800 system clocks per frame. The ideal figure is 50,000,000/60, about 833,333 clocks, and the default is within one line period of it. All geometry is set by parameters.

Top module: `lcd_panel_timing`

## Requirements
- R1: `pix_en_o` is high for exactly one system clock in every DIV clocks (default 10, giving 5 MHz from 50 MHz). It is low in the first clock after reset is released.
- R2: `col_o` changes only on a clock edge where `pix_en_o` is high. On such an edge it goes up by one. From H_TOTAL-1 it wraps to 0, where H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP (default 320+8+10+9 = 347).
- R3: Each line runs through these phases in order: active at columns 0..H_ACTIVE-1, then front porch, then sync, then back porch. `hsync_no` is low (active-low) for exactly H_SYNC pixel periods (H_SYNC*DIV clocks). It first reads low at column H_ACTIVE+H_FP. Falling edges of `hsync_no` are H_TOTAL*DIV clocks apart.
- R4: `row_o` advances by one on the edge where the column wraps from H_TOTAL-1 to 0. From V_ACTIVE-1 it wraps to 0, with no blanking lines, so the row changes V_ACTIVE times per frame.
- R5: `vsync_no` (active-low) goes low when row 0, column 0 begins. It stays low for V_SYNC_PIX pixel periods (V_SYNC_PIX*DIV clocks). Falling edges are V_ACTIVE*H_TOTAL*DIV clocks apart (default 832,800).
- R6: `de_o` is high exactly when `col_o` < H_ACTIVE and `row_o` < V_ACTIVE. Each line holds exactly H_ACTIVE pixel-enable cycles with `de_o` high.
- R7: Reset is asynchronous on `rst_ni` low. While reset is held: column and row are 0, `pix_en_o` is 0, `hsync_no` is 1, `vsync_no` is 0 and `de_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (50 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_o | output | 1 | One-clock pixel-rate enable |
| hsync_no | output | 1 | Horizontal sync, active low |
| vsync_no | output | 1 | Vertical sync, active low |
| de_o | output | 1 | Data enable, high on visible pixels |
| col_o | output | COL_W | Current pixel column |
| row_o | output | ROW_W | Current line |

## Verification
The hardest situation to reach from the ports is the frame boundary. There, the column wrap, the row wrap and the start of the vertical pulse all fall on the same pixel-enable edge. With the default geometry that edge comes only after about 833k clocks. The bench therefore overrides the parameters with a small geometry (DIV 4, 23-pixel line, 6 lines). This lets several frame boundaries occur within a short run. The bench measures sync widths and periods, row sequences and data-enable counts against values computed from the requirement formulas. A reset applied mid-line checks the asynchronous return to the reset state.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;

  typedef enum logic [1:0] {
    LP_ACTIVE,
    LP_FRONT,
    LP_SYNC,
    LP_BACK
  } line_phase_e;

  typedef enum logic {
    VS_PULSE,
    VS_IDLE
  } vs_state_e;

  // 320x240 at 5 MHz: 240 lines of 347 pixels fill one 60 Hz frame
  localparam int unsigned DEF_DIV        = 10;
  localparam int unsigned DEF_H_ACTIVE   = 320;
  localparam int unsigned DEF_H_FP       = 8;
  localparam int unsigned DEF_H_SYNC     = 10;
  localparam int unsigned DEF_H_BP       = 9;
  localparam int unsigned DEF_V_ACTIVE   = 240;
  localparam int unsigned DEF_V_SYNC_PIX = 40;

endpackage

// File: rtl/lcd_pix_div.sv
module lcd_pix_div #(
  parameter int unsigned DIV = 10,
  localparam int unsigned CNT_W = $clog2(DIV)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic pix_en_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_W'(DIV - 1)) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign pix_en_o = (cnt_q == CNT_W'(DIV - 1));

  p_en_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_en_o |=> !pix_en_o);

endmodule

// File: rtl/lcd_line_seq.sv
module lcd_line_seq
  import lcd_timing_pkg::*;
#(
  parameter int unsigned H_ACTIVE = 320,
  parameter int unsigned H_FP     = 8,
  parameter int unsigned H_SYNC   = 10,
  parameter int unsigned H_BP     = 9,
  localparam int unsigned H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP,
  localparam int unsigned COL_W   = $clog2(H_TOTAL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_en_i,
  output logic [COL_W-1:0] col_o,
  output logic             active_o,
  output logic             hsync_no,
  output logic             line_end_o
);

  line_phase_e      state_q, state_d;
  logic [COL_W-1:0] col_q;
  logic [COL_W-1:0] phase_q;
  logic [COL_W-1:0] phase_last;
  logic             phase_done;

  always_comb begin
    unique case (state_q)
      LP_ACTIVE: begin phase_last = COL_W'(H_ACTIVE - 1); state_d = LP_FRONT;  end
      LP_FRONT:  begin phase_last = COL_W'(H_FP - 1);     state_d = LP_SYNC;   end
      LP_SYNC:   begin phase_last = COL_W'(H_SYNC - 1);   state_d = LP_BACK;   end
      default:   begin phase_last = COL_W'(H_BP - 1);     state_d = LP_ACTIVE; end
    endcase
  end

  assign phase_done = (phase_q == phase_last);
  assign line_end_o = pix_en_i && (col_q == COL_W'(H_TOTAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LP_ACTIVE;
      phase_q <= '0;
      col_q   <= '0;
    end else if (pix_en_i) begin
      col_q <= line_end_o ? '0 : col_q + COL_W'(1);
      if (phase_done) begin
        state_q <= state_d;
        phase_q <= '0;
      end else begin
        phase_q <= phase_q + COL_W'(1);
      end
    end
  end

  assign col_o    = col_q;
  assign active_o = (state_q == LP_ACTIVE);
  assign hsync_no = (state_q != LP_SYNC);

  p_col_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_i |=> $stable(col_q));

  p_phase_col_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o == (col_q < COL_W'(H_ACTIVE)));

  p_hsync_zone_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_no |-> (col_q >= COL_W'(H_ACTIVE + H_FP)) &&
                  (col_q <  COL_W'(H_ACTIVE + H_FP + H_SYNC)));

endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq
  import lcd_timing_pkg::*;
#(
  parameter int unsigned V_ACTIVE   = 240,
  parameter int unsigned V_SYNC_PIX = 40,
  parameter int unsigned COL_W      = 9,
  localparam int unsigned ROW_W     = $clog2(V_ACTIVE + 1),
  localparam int unsigned VC_W      = $clog2(V_SYNC_PIX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_en_i,
  input  logic             line_end_i,
  input  logic [COL_W-1:0] col_i,
  output logic [ROW_W-1:0] row_o,
  output logic             vsync_no
);

  vs_state_e        vs_q;
  logic [VC_W-1:0]  vcnt_q;
  logic [ROW_W-1:0] row_q;
  logic             frame_end;

  assign frame_end = line_end_i && (row_q == ROW_W'(V_ACTIVE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
    end else if (line_end_i) begin
      row_q <= frame_end ? '0 : row_q + ROW_W'(1);
    end
  end

  // pulse length counted in pixels, restarted on each frame wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q   <= VS_PULSE;
      vcnt_q <= '0;
    end else if (frame_end) begin
      vs_q   <= VS_PULSE;
      vcnt_q <= '0;
    end else if (pix_en_i && vs_q == VS_PULSE) begin
      if (vcnt_q == VC_W'(V_SYNC_PIX - 1)) begin
        vs_q   <= VS_IDLE;
        vcnt_q <= '0;
      end else begin
        vcnt_q <= vcnt_q + VC_W'(1);
      end
    end
  end

  assign row_o    = row_q;
  assign vsync_no = (vs_q != VS_PULSE);

  p_row_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_end_i |=> $stable(row_q));

  p_vsync_zone_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_no |-> (row_q == '0) && (col_i < COL_W'(V_SYNC_PIX)));

endmodule

// File: rtl/lcd_panel_timing.sv
module lcd_panel_timing
  import lcd_timing_pkg::*;
#(
  parameter int unsigned DIV        = DEF_DIV,
  parameter int unsigned H_ACTIVE   = DEF_H_ACTIVE,
  parameter int unsigned H_FP       = DEF_H_FP,
  parameter int unsigned H_SYNC     = DEF_H_SYNC,
  parameter int unsigned H_BP       = DEF_H_BP,
  parameter int unsigned V_ACTIVE   = DEF_V_ACTIVE,
  parameter int unsigned V_SYNC_PIX = DEF_V_SYNC_PIX,
  localparam int unsigned H_TOTAL   = H_ACTIVE + H_FP + H_SYNC + H_BP,
  localparam int unsigned COL_W     = $clog2(H_TOTAL + 1),
  localparam int unsigned ROW_W     = $clog2(V_ACTIVE + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             pix_en_o,
  output logic             hsync_no,
  output logic             vsync_no,
  output logic             de_o,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o
);

  logic pix_en;
  logic line_active;
  logic line_end;

  lcd_pix_div #(
    .DIV(DIV)
  ) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pix_en_o(pix_en)
  );

  lcd_line_seq #(
    .H_ACTIVE(H_ACTIVE),
    .H_FP    (H_FP),
    .H_SYNC  (H_SYNC),
    .H_BP    (H_BP)
  ) u_line (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pix_en_i  (pix_en),
    .col_o     (col_o),
    .active_o  (line_active),
    .hsync_no  (hsync_no),
    .line_end_o(line_end)
  );

  lcd_frame_seq #(
    .V_ACTIVE  (V_ACTIVE),
    .V_SYNC_PIX(V_SYNC_PIX),
    .COL_W     (COL_W)
  ) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pix_en_i  (pix_en),
    .line_end_i(line_end),
    .col_i     (col_o),
    .row_o     (row_o),
    .vsync_no  (vsync_no)
  );

  assign pix_en_o = pix_en;
  assign de_o     = line_active && (row_o < ROW_W'(V_ACTIVE));

  p_de_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (col_o < COL_W'(H_ACTIVE)));

  p_col_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_o && col_o != COL_W'(H_TOTAL - 1)) |=> (col_o == $past(col_o) + COL_W'(1)));

endmodule

// File: tb/lcd_panel_timing_tb_top.sv
module lcd_panel_timing_tb_top;

  localparam int DIV = 4;
  localparam int HA  = 16;
  localparam int HF  = 2;
  localparam int HS  = 3;
  localparam int HB  = 2;
  localparam int VA  = 6;
  localparam int VSP = 5;
  localparam int HT  = HA + HF + HS + HB;
  localparam int CW  = $clog2(HT + 1);
  localparam int RW  = $clog2(VA + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pix_en, hsync_n, vsync_n, de;
  logic [CW-1:0] col;
  logic [RW-1:0] row;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  lcd_panel_timing #(
    .DIV(DIV), .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_ACTIVE(VA), .V_SYNC_PIX(VSP)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pix_en_o(pix_en), .hsync_no(hsync_n),
    .vsync_no(vsync_n), .de_o(de), .col_o(col), .row_o(row)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset_r7();
    @(negedge clk);
    chk(col == 0, "R7 col", int'(col), 0);
    chk(row == 0, "R7 row", int'(row), 0);
    chk(pix_en == 0, "R7 pix_en", int'(pix_en), 0);
    chk(hsync_n == 1, "R7 hsync", int'(hsync_n), 1);
    chk(vsync_n == 0, "R7 vsync", int'(vsync_n), 0);
    chk(de == 1, "R7 de", int'(de), 1);
  endtask

  task automatic t_pix_en_r1();
    int gap;
    int errs = 0;
    chk(pix_en == 0, "R1 first clock after release", int'(pix_en), 0);
    while (!pix_en) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      gap = 0;
      do begin @(negedge clk); gap++; end while (!pix_en);
      if (gap != DIV) errs++;
    end
    chk(errs == 0, "R1 enable spacing", errs, 0);
  endtask

  task automatic t_col_step_r2();
    int pc, exp;
    bit pe;
    int errs = 0;
    @(negedge clk);
    for (int i = 0; i < 4 * HT * DIV; i++) begin
      pc = int'(col); pe = pix_en;
      @(negedge clk);
      exp = pe ? ((pc == HT - 1) ? 0 : pc + 1) : pc;
      if (int'(col) != exp) errs++;
    end
    chk(errs == 0, "R2 column stepping", errs, 0);
  endtask

  task automatic t_hsync_r3();
    int start_col, width, period;
    while (!hsync_n) @(negedge clk);
    while (hsync_n) @(negedge clk);
    start_col = int'(col);
    chk(start_col == HA + HF, "R3 hsync start column", start_col, HA + HF);
    width = 0; period = 0;
    while (!hsync_n) begin @(negedge clk); width++; period++; end
    chk(width == HS * DIV, "R3 hsync width", width, HS * DIV);
    while (hsync_n) begin @(negedge clk); period++; end
    chk(period == HT * DIV, "R3 line period", period, HT * DIV);
  endtask

  task automatic t_de_r6();
    int cnt = 0;
    int errs = 0;
    while (hsync_n) @(negedge clk);
    while (!hsync_n) @(negedge clk);
    while (hsync_n) begin
      if (de && pix_en) cnt++;
      if (de != (int'(col) < HA)) errs++;
      @(negedge clk);
    end
    while (!hsync_n) begin
      if (de && pix_en) cnt++;
      if (de != (int'(col) < HA)) errs++;
      @(negedge clk);
    end
    chk(cnt == HA, "R6 enabled pixels per line", cnt, HA);
    chk(errs == 0, "R6 de versus column", errs, 0);
  endtask

  task automatic t_frame_r4_r5();
    int width = 0, period = 0, changes = 0, max_row = 0, pr;
    while (!vsync_n) @(negedge clk);
    while (vsync_n) @(negedge clk);
    chk(row == 0 && col == 0, "R5 vsync start position", int'(row) * 100 + int'(col), 0);
    pr = int'(row);
    while (!vsync_n) begin @(negedge clk); width++; period++; end
    chk(width == VSP * DIV, "R5 vsync width", width, VSP * DIV);
    do begin
      if (int'(row) != pr) changes++;
      if (int'(row) > max_row) max_row = int'(row);
      pr = int'(row);
      if (vsync_n) begin @(negedge clk); period++; end
    end while (vsync_n);
    if (int'(row) != pr) changes++;
    chk(period == VA * HT * DIV, "R5 frame period", period, VA * HT * DIV);
    chk(changes == VA, "R4 row changes per frame", changes, VA);
    chk(max_row == VA - 1, "R4 last row", max_row, VA - 1);
  endtask

  task automatic t_mid_reset_r7();
    while (!(row == 2 && col == 9)) @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    chk(col == 0 && row == 0, "R7 async clear position", int'(row) * 100 + int'(col), 0);
    chk(vsync_n == 0 && hsync_n == 1, "R7 async clear syncs",
        int'(vsync_n) * 2 + int'(hsync_n), 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r7();
    rst_n = 1'b1;
    @(negedge clk);
    t_pix_en_r1();
    t_col_step_r2();
    t_hsync_r3();
    t_de_r6();
    t_frame_r4_r5();
    t_frame_r4_r5();
    t_mid_reset_r7();
    t_pix_en_r1();
    t_hsync_r3();
    t_frame_r4_r5();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule